// File: doc/BRIEF.md
# Serial Bitstream Input Buffer

This block accepts a compressed audio bitstream arriving on a single serial data line with its own bit clock and a bit-enable qualifier. It moves all three lines into the system clock domain and detects the configured edge of the bit clock there. On each qualified edge it shifts one data bit into a byte register, most significant bit first. Finished bytes are written into a 256-entry byte FIFO, which a downstream consumer drains one byte per read request.

The block drives a flow-control request line back to the data source. The line tells the source to keep sending until the FIFO holds more than 252 bytes. That leaves room for the 4 bytes that may still be in flight once the source sees the line change. The active level of the request line and the sampling edge of the bit clock are both set through plain configuration inputs. A control register driving those inputs should start at active-high request and falling-edge sampling. The consumer side sees a fill count, empty and full flags, and sticky flags that record a dropped byte and a read of an empty FIFO.

Top module: `sbi_buffer`

## Requirements
- R1: Serial bits are packed most significant bit first. The first bit sampled after a completed byte (or after reset) lands in bit 7, and the eighth lands in bit 0.
- R2: The FIFO holds exactly 256 bytes. After 256 bytes are written with no reads, `full` is 1 and `fill` is 256.
- R3: A byte that completes while the FIFO is full is discarded and `overflow` goes to 1 and stays 1 until reset. The stored bytes and their order are unchanged.
- R4: With `cfg_req_inv` = 0, `req` is 1 while `fill` is 252 or less and 0 while `fill` is 253 to 256.
- R5: With `cfg_req_inv` = 1, `req` is the complement of its R4 value for the same fill.
- R6: With `cfg_sample_fall` = 0, data is sampled on the rising edge of `ser_clk`. With `cfg_sample_fall` = 1, data is sampled on the falling edge. The value 1 corresponds to the falling-edge default.
- R7: While `ser_en` is 0, edges of `ser_clk` are ignored and a partly assembled byte is held. Assembly continues with the next bit once `ser_en` returns to 1.
- R8: A read request while `fill` is 0 produces no `rd_valid` and sets `underflow`, which stays 1 until reset.
- R9: A read request while `fill` is nonzero makes `rd_valid` 1 for one cycle on the next clock, with the oldest stored byte on `rd_data`. `fill`, `empty` and `full` track the number of stored bytes.
- R10: After reset, `fill` is 0, `empty` is 1, `full`, `overflow` and `underflow` are 0, and `req` is 1 when `cfg_req_inv` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock from the source |
| ser_data | input | 1 | Serial data line |
| ser_en | input | 1 | Bit enable; bits are ignored while low |
| cfg_sample_fall | input | 1 | 1 = sample on the falling edge, 0 = sample on the rising edge |
| cfg_req_inv | input | 1 | 1 = request line active low |
| rd_en | input | 1 | Consumer read request |
| rd_data | output | 8 | Byte returned by a read |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| fill | output | 9 | Number of stored bytes |
| empty | output | 1 | FIFO holds no bytes |
| full | output | 1 | FIFO holds 256 bytes |
| overflow | output | 1 | Sticky: a byte was dropped |
| underflow | output | 1 | Sticky: a read found the FIFO empty |
| req | output | 1 | Flow-control request to the source |

## Verification
The assertions check on every cycle the behaviour that follows from one or two registers:
- a held bit count while the enable is low;
- a dropped byte raising the overflow flag;
- an empty-FIFO read producing no valid data and raising the underflow flag;
- a fill count that moves only on accepted transfers;
- the request line closed whenever the FIFO is full.

The bench scenarios are what show that bytes come out in MSB-first order and in arrival order, that only the configured clock edge captures data, and that a paused byte resumes intact. They also show the exact switch of the request line between 252 and 253 bytes in both polarities.

// File: rtl/sbi_pkg.sv
package sbi_pkg;
    // Width of one assembled bitstream unit
    parameter int unsigned SBI_DATA_W = 8;
    // Bit counter width for one unit
    parameter int unsigned SBI_BIT_CNT_W = $clog2(SBI_DATA_W);
    // Stages in each clock-domain synchronizer
    parameter int unsigned SBI_SYNC_STAGES = 2;
endpackage

// File: rtl/sbi_sync.sv
module sbi_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = sbi_pkg::SBI_SYNC_STAGES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_in;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sbi_deser.sv
module sbi_deser
    import sbi_pkg::*;
#(
    parameter int unsigned DW = SBI_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sclk_s,
    input  logic          sdat_s,
    input  logic          sen_s,
    input  logic          sample_fall,
    output logic          byte_vld,
    output logic [DW-1:0] byte_dat
);
    localparam int unsigned CW = $clog2(DW);

    typedef struct packed {
        logic          prev;
        logic [DW-1:0] shift;
        logic [CW-1:0] cnt;
        logic          vld;
        logic [DW-1:0] dat;
    } deser_st_t;

    deser_st_t st_d, st_q;
    logic      rise, fall, smp;

    always_comb begin
        st_d      = st_q;
        st_d.vld  = 1'b0;
        st_d.prev = sclk_s;
        rise      = sclk_s & ~st_q.prev;
        fall      = ~sclk_s & st_q.prev;
        smp       = sample_fall ? fall : rise;
        if (smp && sen_s) begin
            st_d.shift = {st_q.shift[DW-2:0], sdat_s};
            if (st_q.cnt == CW'(DW - 1)) begin
                st_d.vld = 1'b1;
                st_d.dat = {st_q.shift[DW-2:0], sdat_s};
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_vld = st_q.vld;
    assign byte_dat = st_q.dat;

    // R7: a low enable freezes the partial byte position
    p_hold_partial_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sen_s |=> $stable(st_q.cnt));
endmodule

// File: rtl/sbi_fifo.sv
module sbi_fifo
    import sbi_pkg::*;
#(
    parameter int unsigned DW    = SBI_DATA_W,
    parameter int unsigned DEPTH = 256
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [DW-1:0] wdat,
    input  logic          rd,
    output logic [DW-1:0] rdat,
    output logic          rvld,
    output logic [$clog2(DEPTH):0] cnt,
    output logic          ovf,
    output logic          unf
);
    localparam int unsigned AW = $clog2(DEPTH);
    localparam int unsigned FW = AW + 1;

    typedef struct packed {
        logic [AW-1:0] wptr;
        logic [AW-1:0] rptr;
        logic [FW-1:0] cnt;
        logic [DW-1:0] rdat;
        logic          rvld;
        logic          ovf;
        logic          unf;
    } fifo_st_t;

    fifo_st_t      st_d, st_q;
    logic [DW-1:0] mem [DEPTH];
    logic          is_full, is_empty, wr_ok, rd_ok;

    always_comb begin
        st_d     = st_q;
        is_full  = (st_q.cnt == FW'(DEPTH));
        is_empty = (st_q.cnt == '0);
        wr_ok    = wr && !is_full;
        rd_ok    = rd && !is_empty;
        st_d.rvld = rd_ok;
        if (wr_ok) st_d.wptr = st_q.wptr + 1'b1;
        if (rd_ok) begin
            st_d.rdat = mem[st_q.rptr];
            st_d.rptr = st_q.rptr + 1'b1;
        end
        if (wr_ok && !rd_ok)      st_d.cnt = st_q.cnt + 1'b1;
        else if (rd_ok && !wr_ok) st_d.cnt = st_q.cnt - 1'b1;
        if (wr && is_full)  st_d.ovf = 1'b1;
        if (rd && is_empty) st_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (wr_ok) mem[st_q.wptr] <= wdat;
    end

    assign rdat = st_q.rdat;
    assign rvld = st_q.rvld;
    assign cnt  = st_q.cnt;
    assign ovf  = st_q.ovf;
    assign unf  = st_q.unf;

    // R3: a write into a full buffer is flagged
    p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && st_q.cnt == FW'(DEPTH) && !rd) |=> (st_q.ovf && st_q.cnt == FW'(DEPTH)));
    // R8: an empty read yields no data and is flagged
    p_empty_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && st_q.cnt == '0) |=> (!st_q.rvld && st_q.unf));
    // R9: fill only moves on an accepted transfer
    p_fill_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr && !rd) |=> $stable(st_q.cnt));
endmodule

// File: rtl/sbi_buffer.sv
module sbi_buffer
    import sbi_pkg::*;
#(
    parameter int unsigned DW    = SBI_DATA_W,
    parameter int unsigned DEPTH = 256,
    parameter int unsigned SLACK = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ser_clk,
    input  logic                   ser_data,
    input  logic                   ser_en,
    input  logic                   cfg_sample_fall,
    input  logic                   cfg_req_inv,
    input  logic                   rd_en,
    output logic [DW-1:0]          rd_data,
    output logic                   rd_valid,
    output logic [$clog2(DEPTH):0] fill,
    output logic                   empty,
    output logic                   full,
    output logic                   overflow,
    output logic                   underflow,
    output logic                   req
);
    localparam int unsigned FW     = $clog2(DEPTH) + 1;
    localparam int unsigned THRESH = DEPTH - SLACK;

    logic [2:0]    raw_lines, sync_lines;
    logic          byte_vld;
    logic [DW-1:0] byte_dat;
    logic          room_left;

    assign raw_lines = {ser_en, ser_data, ser_clk};

    sbi_sync #(.WIDTH(3)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_lines),
        .sync_out (sync_lines)
    );

    sbi_deser #(.DW(DW)) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_s      (sync_lines[0]),
        .sdat_s      (sync_lines[1]),
        .sen_s       (sync_lines[2]),
        .sample_fall (cfg_sample_fall),
        .byte_vld    (byte_vld),
        .byte_dat    (byte_dat)
    );

    sbi_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (byte_vld),
        .wdat  (byte_dat),
        .rd    (rd_en),
        .rdat  (rd_data),
        .rvld  (rd_valid),
        .cnt   (fill),
        .ovf   (overflow),
        .unf   (underflow)
    );

    always_comb begin
        room_left = (fill <= FW'(THRESH));
        req       = room_left ^ cfg_req_inv;
        empty     = (fill == '0);
        full      = (fill == FW'(DEPTH));
    end

    // R4: a full buffer always tells the source to stop
    p_full_stops_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (u_fifo.cnt == FW'(DEPTH)) |-> (req == cfg_req_inv));
endmodule

// File: tb/sbi_buffer_test.sv
module sbi_buffer_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ser_clk, ser_data, ser_en;
    logic       cfg_sample_fall, cfg_req_inv, rd_en;
    logic [7:0] rd_data;
    logic       rd_valid, empty, full, overflow, underflow, req;
    logic [8:0] fill;

    int n_chk  = 0;
    int n_fail = 0;
    logic [7:0] model [0:1023];
    int wr_i = 0;
    int rd_i = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sbi_buffer uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_en(ser_en), .cfg_sample_fall(cfg_sample_fall),
        .cfg_req_inv(cfg_req_inv), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .fill(fill), .empty(empty), .full(full),
        .overflow(overflow), .underflow(underflow), .req(req)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present a bit, make the sampling edge, then swap to the inverse on the return edge
    task automatic send_bit(input logic b);
        @(negedge clk);
        ser_data = b;
        repeat (HALF) @(negedge clk);
        ser_clk = ~ser_clk;
        repeat (HALF) @(negedge clk);
        ser_data = ~b;
        ser_clk  = ~ser_clk;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit keep);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        repeat (6) @(negedge clk);
        if (keep) begin
            model[wr_i] = b;
            wr_i++;
        end
    endtask

    task automatic read_one(input string tag);
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk({tag, " rd_valid"}, 32'(rd_valid), 32'd1);
        chk({tag, " data"}, 32'(rd_data), 32'(model[rd_i]));
        rd_i++;
    endtask

    function automatic logic exp_req(input int level, input logic inv);
        return (level <= 252) ^ inv;
    endfunction

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'd4242));
        rst_n = 1'b0; ser_clk = 1'b0; ser_data = 1'b0; ser_en = 1'b0;
        cfg_sample_fall = 1'b0; cfg_req_inv = 1'b0; rd_en = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R10 reset state
        chk("R10 fill", 32'(fill), 32'd0);
        chk("R10 empty", 32'(empty), 32'd1);
        chk("R10 full", 32'(full), 32'd0);
        chk("R10 flags", 32'({overflow, underflow}), 32'd0);
        chk("R10 req", 32'(req), 32'd1);

        // R8 read while empty
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
        chk("R8 no rd_valid", 32'(rd_valid), 32'd0);
        chk("R8 underflow", 32'(underflow), 32'd1);
        repeat (3) @(negedge clk);
        chk("R8 underflow sticky", 32'(underflow), 32'd1);

        // R1/R9 random bytes, rising-edge sampling
        ser_en = 1'b1;
        for (int k = 0; k < 20; k++) begin
            b = 8'($urandom);
            if (k == 0) b = 8'h80;
            if (k == 1) b = 8'h01;
            send_byte(b, 1'b1);
        end
        chk("R9 fill after 20", 32'(fill), 32'd20);
        chk("R9 empty low", 32'(empty), 32'd0);
        for (int k = 0; k < 20; k++) read_one("R1 msb-first");
        @(negedge clk);
        chk("R9 empty after drain", 32'(empty), 32'd1);

        // R6 falling-edge sampling
        ser_en = 1'b0;
        @(negedge clk); ser_clk = 1'b1; cfg_sample_fall = 1'b1;
        repeat (6) @(negedge clk);
        ser_en = 1'b1;
        for (int k = 0; k < 10; k++) send_byte(8'($urandom), 1'b1);
        chk("R6 fill falling", 32'(fill), 32'd10);
        for (int k = 0; k < 10; k++) read_one("R6 falling edge");

        // R6 back to rising edge
        ser_en = 1'b0;
        @(negedge clk); ser_clk = 1'b0; cfg_sample_fall = 1'b0;
        repeat (6) @(negedge clk);
        ser_en = 1'b1;
        for (int k = 0; k < 6; k++) send_byte(8'($urandom), 1'b1);
        for (int k = 0; k < 6; k++) read_one("R6 rising edge");

        // R7 pause in the middle of a byte
        b = 8'hA6;
        for (int i = 7; i >= 5; i--) send_bit(b[i]);
        @(negedge clk); ser_en = 1'b0;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 5; i++) send_bit(1'b1);
        repeat (6) @(negedge clk);
        chk("R7 nothing during pause", 32'(fill), 32'd0);
        ser_en = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 4; i >= 0; i--) send_bit(b[i]);
        repeat (6) @(negedge clk);
        model[wr_i] = b; wr_i++;
        chk("R7 one byte", 32'(fill), 32'd1);
        read_one("R7 resumed byte");

        // R4/R5 threshold, R2 capacity, R3 overflow
        for (int k = 0; k < 252; k++) send_byte(8'($urandom), 1'b1);
        chk("R4 req at 252", 32'(req), 32'(exp_req(252, 1'b0)));
        cfg_req_inv = 1'b1; #1;
        chk("R5 req inverted at 252", 32'(req), 32'(exp_req(252, 1'b1)));
        cfg_req_inv = 1'b0;
        send_byte(8'($urandom), 1'b1);
        chk("R4 req at 253", 32'(req), 32'(exp_req(253, 1'b0)));
        cfg_req_inv = 1'b1; #1;
        chk("R5 req inverted at 253", 32'(req), 32'(exp_req(253, 1'b1)));
        cfg_req_inv = 1'b0;
        for (int k = 0; k < 3; k++) send_byte(8'($urandom), 1'b1);
        chk("R2 fill 256", 32'(fill), 32'd256);
        chk("R2 full", 32'(full), 32'd1);
        chk("R3 no overflow yet", 32'(overflow), 32'd0);
        send_byte(8'h5A, 1'b0);
        chk("R3 overflow", 32'(overflow), 32'd1);
        chk("R3 fill held", 32'(fill), 32'd256);
        chk("R4 req closed when full", 32'(req), 32'd0);
        for (int k = 0; k < 256; k++) read_one("R3 order kept");
        @(negedge clk);
        chk("R9 empty at end", 32'(empty), 32'd1);
        chk("R3 overflow sticky", 32'(overflow), 32'd1);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule